// File: doc/BRIEF.md
# Timer Interrupt Reinjection Controller

This block sits between a timer's expiry strobe and an edge-style interrupt line. It does not pass each expiry straight through. It keeps a credit counter of timer ticks that have not yet been delivered. It sends one interrupt pulse at a time, and it sends the next one only after the interrupt controller has acknowledged the previous one. This way, a guest that falls behind still receives every tick, but never two of them stacked into one edge.

Acknowledges that arrive when no tick is outstanding are clamped, so the counter never goes below zero. Reprogramming the timer, or unmasking the interrupt, discards the backlog and re-arms delivery. When reinjection is turned off, an expiry is accepted only if nothing is outstanding, so the timer tends to drop ticks rather than pile them up. The block also latches the reload period given at reprogramming. If the reload is periodic, any period below a configured floor is raised to that floor.

Top module: `tick_reinject_ctrl`

## Requirements
- R1: After synchronous reset, `irq_out` is 0, `credit_count` is 0, `eff_period` is 0, and delivery is armed, so the first accepted expiry is delivered without a prior acknowledge.
- R2: An expiry with `reinject_en`=1 raises `credit_count` by one and schedules a delivery. If delivery is armed, `irq_out` goes high in the second cycle after the expiry is sampled.
- R3: An expiry with `reinject_en`=0 while `credit_count` is nonzero is dropped. The count does not change and no pulse follows.
- R4: A scheduled delivery produces a pulse only while delivery is armed. The pulse disarms delivery, so later expiries produce no pulse until an acknowledge, unmask or reprogram arrives.
- R5: Each delivery drives `irq_out` high for exactly one cycle and then low.
- R6: An acknowledge lowers `credit_count` by one. An acknowledge at a count of zero leaves it at zero.
- R7: Every acknowledge re-arms delivery. If the count after the acknowledge is still above zero, a new delivery is scheduled and its pulse appears in the second cycle after the acknowledge.
- R8: A reprogram clears `credit_count` to zero, re-arms delivery, and cancels any scheduled delivery.
- R9: An unmask clears `credit_count` to zero and re-arms delivery.
- R10: On reprogram, `eff_period` takes `reprog_period`. If `reprog_periodic`=1 and the period is below MIN_PERIOD, `eff_period` takes MIN_PERIOD instead. A one-shot reload is never raised.
- R11: `credit_count` saturates at its all-ones value. Further accepted expiries leave it there.
- R12: An expiry and an acknowledge sampled in the same cycle are applied as one net update. With reinjection on and a nonzero count, the count is unchanged and a delivery is scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_expire | input | 1 | One-cycle strobe: the timer has expired |
| irq_ack | input | 1 | One-cycle strobe: the interrupt controller acknowledged |
| irq_unmask | input | 1 | One-cycle strobe: the interrupt line was unmasked |
| timer_reprog | input | 1 | One-cycle strobe: the timer is reprogrammed |
| reprog_periodic | input | 1 | With `timer_reprog`: 1 means periodic reload, 0 means one-shot |
| reprog_period | input | PERIOD_W | With `timer_reprog`: requested reload period |
| reinject_en | input | 1 | 1 means accumulate every expiry; 0 means drop an expiry while one is outstanding |
| irq_out | output | 1 | Registered interrupt pulse |
| credit_count | output | CREDIT_W | Undelivered tick count |
| eff_period | output | PERIOD_W | Period in force after the floor is applied |

## Verification
Two functions can land in the same cycle: an expiry that adds credit and an acknowledge that removes it. The bench first builds up a count of two with one delivery outstanding. It then drives `tick_expire` and `irq_ack` on the same edge and expects the count to stay at two, with exactly one new pulse two cycles later. It then retires the remaining credit by single acknowledges and expects one further pulse and then silence. Every pulse goes through a scoreboard that matches each pulse to the cycle in which it is due, so a lost, extra or late delivery is reported.

// File: rtl/tick_reinject_pkg.sv
package tick_reinject_pkg;

  // Raise a periodic reload to the floor; leave one-shot reloads alone.
  function automatic logic [31:0] floor_period(
    input logic        periodic,
    input logic [31:0] req,
    input logic [31:0] floor_val
  );
    if (periodic && (req < floor_val)) floor_period = floor_val;
    else                               floor_period = req;
  endfunction

  typedef enum logic [1:0] {
    DLV_IDLE  = 2'd0,
    DLV_PULSE = 2'd1
  } dlv_state_e;

endpackage

// File: rtl/tick_credit_counter.sv
module tick_credit_counter #(
  parameter int CREDIT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                expire_i,
  input  logic                ack_i,
  input  logic                clear_i,
  input  logic                reinject_i,
  output logic [CREDIT_W-1:0] count_o,
  output logic                sched_o
);
  localparam logic [CREDIT_W-1:0] MAX_CNT = {CREDIT_W{1'b1}};
  localparam int                  SUM_W   = CREDIT_W + 1;

  logic [CREDIT_W-1:0] cnt_q, cnt_d;
  logic                accept;
  logic [SUM_W-1:0]    sum;

  // An expiry is accepted when reinjection is on or nothing is outstanding.
  assign accept = expire_i && (reinject_i || (cnt_q == '0));
  assign sum    = {1'b0, cnt_q} + {{CREDIT_W{1'b0}}, accept};

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (ack_i) begin
      if (sum == '0) cnt_d = '0;                        // spurious acknowledge
      else           cnt_d = CREDIT_W'(sum - SUM_W'(1));
    end else if (sum > {1'b0, MAX_CNT}) begin
      cnt_d = MAX_CNT;                                  // saturate
    end else begin
      cnt_d = sum[CREDIT_W-1:0];
    end
  end

  assign sched_o = !clear_i && (accept || (ack_i && (sum > SUM_W'(1))));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_spurious_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !expire_i && !clear_i && cnt_q == '0) |=> (cnt_q == '0));

  assert_saturate_R11: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !ack_i && !clear_i && cnt_q == MAX_CNT) |=> (cnt_q == MAX_CNT));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));

  assert_net_update_R12: assert property (@(posedge clk) disable iff (rst)
    (expire_i && ack_i && reinject_i && !clear_i && cnt_q != '0 && cnt_q != MAX_CNT)
      |=> (cnt_q == $past(cnt_q)));

  assert_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (expire_i && !ack_i && !clear_i && !reinject_i && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/tick_delivery.sv
module tick_delivery
  import tick_reinject_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sched_i,
  input  logic arm_i,
  input  logic cancel_i,
  output logic irq_o
);
  logic       work_q;
  logic       armed_q;
  dlv_state_e st_q;
  logic       consume, fire;

  // Scheduled work is consumed whenever the line is idle; it fires only if armed.
  assign consume = work_q && (st_q == DLV_IDLE);
  assign fire    = consume && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= 1'b0;
      armed_q <= 1'b1;
      st_q    <= DLV_IDLE;
    end else begin
      if (cancel_i)     work_q <= 1'b0;
      else if (sched_i) work_q <= 1'b1;
      else if (consume) work_q <= 1'b0;

      if (arm_i)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;

      st_q <= fire ? DLV_PULSE : DLV_IDLE;
    end
  end

  assign irq_o = (st_q == DLV_PULSE);

  assert_one_cycle_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  assert_needs_arm_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(armed_q));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> armed_q);
endmodule

// File: rtl/tick_period_floor.sv
module tick_period_floor
  import tick_reinject_pkg::*;
#(
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                periodic_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [PERIOD_W-1:0] period_o
);
  localparam logic [31:0] FLOOR = 32'(MIN_PERIOD);

  logic [PERIOD_W-1:0] per_q;
  logic [31:0]         picked;

  assign picked = floor_period(periodic_i, 32'(period_i), FLOOR);

  always_ff @(posedge clk) begin
    if (rst)         per_q <= '0;
    else if (load_i) per_q <= PERIOD_W'(picked);
  end

  assign period_o = per_q;

  assert_floor_R10: assert property (@(posedge clk) disable iff (rst)
    (load_i && periodic_i) |=> (32'(per_q) >= FLOOR));

  assert_oneshot_R10: assert property (@(posedge clk) disable iff (rst)
    (load_i && !periodic_i) |=> (per_q == $past(period_i)));
endmodule

// File: rtl/tick_reinject_ctrl.sv
module tick_reinject_ctrl #(
  parameter int CREDIT_W   = 8,
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_expire,
  input  logic                irq_ack,
  input  logic                irq_unmask,
  input  logic                timer_reprog,
  input  logic                reprog_periodic,
  input  logic [PERIOD_W-1:0] reprog_period,
  input  logic                reinject_en,
  output logic                irq_out,
  output logic [CREDIT_W-1:0] credit_count,
  output logic [PERIOD_W-1:0] eff_period
);
  logic clear, arm, sched;

  assign clear = timer_reprog || irq_unmask;
  assign arm   = irq_ack || clear;

  tick_credit_counter #(.CREDIT_W(CREDIT_W)) u_credit (
    .clk(clk), .rst(rst),
    .expire_i(tick_expire), .ack_i(irq_ack), .clear_i(clear),
    .reinject_i(reinject_en),
    .count_o(credit_count), .sched_o(sched)
  );

  tick_delivery u_dlv (
    .clk(clk), .rst(rst),
    .sched_i(sched), .arm_i(arm), .cancel_i(timer_reprog),
    .irq_o(irq_out)
  );

  tick_period_floor #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_floor (
    .clk(clk), .rst(rst),
    .load_i(timer_reprog), .periodic_i(reprog_periodic), .period_i(reprog_period),
    .period_o(eff_period)
  );

  assert_first_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_expire && !clear && reinject_en && credit_count == '0 && !irq_ack)
      |=> (credit_count == CREDIT_W'(1)));

  assert_unmask_R9: assert property (@(posedge clk) disable iff (rst)
    irq_unmask |=> (credit_count == '0));
endmodule

// File: tb/tb_tick_reinject_ctrl.sv
module tb_tick_reinject_ctrl;
  localparam int CW = 3;
  localparam int PW = 16;
  localparam int MINP = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_expire = 0, irq_ack = 0, irq_unmask = 0, timer_reprog = 0;
  logic reprog_periodic = 0, reinject_en = 1;
  logic [PW-1:0] reprog_period = '0;
  logic irq_out;
  logic [CW-1:0] credit_count;
  logic [PW-1:0] eff_period;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];
  bit done = 0;
  bit prev_irq = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_reinject_ctrl #(.CREDIT_W(CW), .PERIOD_W(PW), .MIN_PERIOD(MINP)) dut (
    .clk(clk), .rst(rst), .tick_expire(tick_expire), .irq_ack(irq_ack),
    .irq_unmask(irq_unmask), .timer_reprog(timer_reprog),
    .reprog_periodic(reprog_periodic), .reprog_period(reprog_period),
    .reinject_en(reinject_en), .irq_out(irq_out),
    .credit_count(credit_count), .eff_period(eff_period)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: every pulse must match the scoreboard; pulses last one cycle.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (irq_out) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: actual pulse at cycle %0d expected none", cyc);
        end else begin
          check("R2/R7 pulse cycle", cyc, exp_q.pop_front());
        end
        if (prev_irq) check("R5 pulse width", 2, 1);
      end
      prev_irq = irq_out;
    end
  end

  // Driver: apply strobes for one edge; optionally enqueue the expected pulse.
  task automatic hit(input bit e, input bit a, input bit u, input bit r, input bit want);
    @(negedge clk);
    tick_expire = e; irq_ack = a; irq_unmask = u; timer_reprog = r;
    @(posedge clk);
    @(negedge clk);
    if (want) exp_q.push_back(cyc + 1);
    tick_expire = 0; irq_ack = 0; irq_unmask = 0; timer_reprog = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 irq", irq_out, 0);
    check("R1 count", credit_count, 0);
    check("R1 period", eff_period, 0);

    hit(1,0,0,0,1); check("R2 count", credit_count, 1);
    hit(1,0,0,0,0); check("R4 count", credit_count, 2);
    hit(0,1,0,0,1); check("R7 count", credit_count, 1);
    hit(0,1,0,0,0); check("R6 count", credit_count, 0);
    hit(0,1,0,0,0); check("R6 spurious", credit_count, 0);

    reinject_en = 0;
    hit(1,0,0,0,1); check("R3 accept at zero", credit_count, 1);
    hit(1,0,0,0,0); check("R3 dropped", credit_count, 1);
    hit(0,1,0,0,0); check("R3 drained", credit_count, 0);
    reinject_en = 1;

    // Expiry and acknowledge on the same edge.
    hit(1,0,0,0,1); hit(1,0,0,0,0);
    check("R12 setup", credit_count, 2);
    hit(1,1,0,0,1); check("R12 net", credit_count, 2);
    hit(0,1,0,0,1); check("R12 drain1", credit_count, 1);
    hit(0,1,0,0,0); check("R12 drain2", credit_count, 0);

    hit(1,0,0,0,1); hit(1,0,0,0,0);
    hit(0,0,0,1,0); check("R8 clear", credit_count, 0);
    hit(1,0,0,0,1); check("R8 rearmed", credit_count, 1);
    hit(1,0,0,0,0);
    hit(0,0,1,0,0); check("R9 clear", credit_count, 0);
    hit(1,0,0,0,1); check("R9 rearmed", credit_count, 1);
    hit(0,1,0,0,0);

    // Saturation: first expiry delivers, the rest pile up.
    hit(1,0,0,0,1);
    for (int i = 0; i < 9; i++) hit(1,0,0,0,0);
    check("R11 saturated", credit_count, 7);
    hit(0,0,0,1,0);

    reprog_periodic = 1; reprog_period = 16'd10;
    hit(0,0,0,1,0); check("R10 floor", eff_period, MINP);
    reprog_period = 16'd100;
    hit(0,0,0,1,0); check("R10 above floor", eff_period, 100);
    reprog_periodic = 0; reprog_period = 16'd10;
    hit(0,0,0,1,0); check("R10 one-shot", eff_period, 10);

    repeat (5) @(negedge clk);
    check("R4 scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule